// File: doc/BRIEF.md
# Timer Status Flag Register

This block keeps the four event flags of a 16-bit timer/counter and presents them to the processor as one 8-bit status register. The flags are input capture, compare match on channel A, compare match on channel B, and overflow. The surrounding counter logic supplies its count value, the two compare values, the capture register value, the capture pulse, the force-compare strobes, the overflow and mode-selected overflow pulses, and the waveform mode bits. Hardware sets a flag only on a timer clock-enable tick. A flag can be cleared on any system clock cycle, either by its interrupt-acknowledge pulse or by software writing a one to its bit.

Each compare flag is raised on the tick that follows a tick on which the count equals the compare value. A forced compare never raises it. When the mode uses the capture register as the counter's TOP, the capture flag instead marks the count reaching that register's value. The overflow flag follows the counter's own overflow pulse in the normal and clear-on-compare modes, and follows a separate mode-selected event in every other mode. Each flag, AND-ed with its own enable input, drives an interrupt request line.

Top module: `tmr_flag_reg`

## Requirements
- R1: After the asynchronous active-low reset, every bit of `rd_data` and every bit of `irq` is 0.
- R2: The register layout is capture flag at bit 5, compare-B at bit 2, compare-A at bit 1 and overflow at bit 0. Bits 7, 6, 4 and 3 always read 0, and writes to them have no effect.
- R3: When `top_is_cap` is 0, a tick on which `cap_evt` is 1 sets bit 5. A `cap_evt` pulse without a tick leaves bit 5 clear.
- R4: When `top_is_cap` is 1, bit 5 is set on a tick where `cnt` equals `cap_val`, and `cap_evt` is ignored.
- R5: A tick where `cnt` equals `cmp_a` (or `cmp_b`) sets bit 1 (or bit 2) on the next tick, not on the matching tick.
- R6: A matching tick that carries that channel's force strobe (`force_a` or `force_b`) never sets that channel's flag.
- R7: With `mode` equal to 0, 4 or 12, a tick with `ovf_evt` sets bit 0 and `alt_ovf_evt` is ignored. With any other mode the roles of the two inputs are swapped.
- R8: An `ack` pulse clears its flag on the next clock. The `ack` index order is 0 for overflow, 1 for compare-A, 2 for compare-B and 3 for capture.
- R9: A write (`wr_en`=1) clears every flag whose bit in `wr_data` is 1, and leaves the flags whose bit is 0 unchanged.
- R10: When a hardware set and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag ends up set.
- R11: A clear takes effect on a clock where `tick` is 0.
- R12: `irq[i]` is flag i AND `irq_en[i]`, using the `ack` index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable; gates every set |
| cnt | input | CNT_W | Current counter value |
| cmp_a | input | CNT_W | Compare value, channel A |
| cmp_b | input | CNT_W | Compare value, channel B |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| cap_evt | input | 1 | Capture event pulse |
| cap_val | input | CNT_W | Capture register value (TOP in capture-TOP modes) |
| top_is_cap | input | 1 | Mode uses capture register as TOP |
| mode | input | 4 | Waveform mode bits |
| ovf_evt | input | 1 | Counter overflow pulse |
| alt_ovf_evt | input | 1 | Mode-selected overflow event for other modes |
| ack | input | 4 | Per-flag interrupt acknowledge pulses |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_en | input | 4 | Per-flag interrupt enables |
| irq | output | 4 | Per-flag interrupt requests |

## Verification
The bench builds the block with a 4-bit counter width. At that width, every pairing of count and compare value (and of count and capture value) can be swept, so the one-tick delay and its equality test are checked at every value. All 16 mode codes are swept against both overflow sources, and all 16 enable patterns are swept against the set flags. Set-versus-clear collisions, clears between ticks and forced matches are each driven directly.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int FLG_N  = 4;
  localparam int REG_W  = 8;
  localparam int MODE_W = 4;

  localparam int IDX_OVF = 0;
  localparam int IDX_CA  = 1;
  localparam int IDX_CB  = 2;
  localparam int IDX_CAP = 3;

  // register bit position of each flag index
  function automatic int flag_pos(input int idx);
    case (idx)
      IDX_OVF: return 0;
      IDX_CA:  return 1;
      IDX_CB:  return 2;
      default: return 5;
    endcase
  endfunction

  // modes in which the counter's own overflow drives the overflow flag
  function automatic logic ovf_direct(input logic [MODE_W-1:0] m);
    return (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
  endfunction
endpackage

// File: rtl/tfr_flag.sv
module tfr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (clr_i) q_nxt = 1'b0;
    if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/tfr_match.sv
module tfr_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             force_stb,
  output logic             pend_o
);
  logic pend_nxt;
  logic hit;

  always_comb begin
    hit      = (cnt == cmp) && !force_stb;
    pend_nxt = pend_o;
    if (tick) pend_nxt = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_nxt;
  end

  assert_force_no_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_stb) |=> !pend_o);
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pend_o));
endmodule

// File: rtl/tfr_src.sv
module tfr_src
  import tfr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              tick,
  input  logic              cap_evt,
  input  logic              top_is_cap,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic [MODE_W-1:0] mode,
  input  logic              ovf_evt,
  input  logic              alt_ovf_evt,
  input  logic              pend_a,
  input  logic              pend_b,
  output logic [FLG_N-1:0]  set_o
);
  logic cap_src;
  logic ovf_src;

  always_comb begin
    cap_src = top_is_cap ? (cnt == cap_val) : cap_evt;
    ovf_src = ovf_direct(mode) ? ovf_evt : alt_ovf_evt;
    set_o          = '0;
    set_o[IDX_OVF] = tick && ovf_src;
    set_o[IDX_CA]  = tick && pend_a;
    set_o[IDX_CB]  = tick && pend_b;
    set_o[IDX_CAP] = tick && cap_src;
  end
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
  import tfr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic              force_a,
  input  logic              force_b,
  input  logic              cap_evt,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic              top_is_cap,
  input  logic [MODE_W-1:0] mode,
  input  logic              ovf_evt,
  input  logic              alt_ovf_evt,
  input  logic [FLG_N-1:0]  ack,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [FLG_N-1:0]  irq_en,
  output logic [FLG_N-1:0]  irq
);
  logic [FLG_N-1:0] set_v;
  logic [FLG_N-1:0] clr_v;
  logic [FLG_N-1:0] flg;
  logic             pend_a;
  logic             pend_b;

  tfr_match #(.CNT_W(CNT_W)) u_ma (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp(cmp_a),
    .force_stb(force_a), .pend_o(pend_a));

  tfr_match #(.CNT_W(CNT_W)) u_mb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp(cmp_b),
    .force_stb(force_b), .pend_o(pend_b));

  tfr_src #(.CNT_W(CNT_W)) u_src (
    .tick(tick), .cap_evt(cap_evt), .top_is_cap(top_is_cap), .cnt(cnt),
    .cap_val(cap_val), .mode(mode), .ovf_evt(ovf_evt),
    .alt_ovf_evt(alt_ovf_evt), .pend_a(pend_a), .pend_b(pend_b),
    .set_o(set_v));

  for (genvar i = 0; i < FLG_N; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    assign clr_v[i] = ack[i] || (wr_en && wr_data[POS]);
    tfr_flag u_f (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]),
      .q_o(flg[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < FLG_N; i++) rd_data[flag_pos(i)] = flg[i];
    irq = flg & irq_en;
  end

  assert_cmp_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_a) |=> rd_data[1]);
  assert_ovf_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ovf_direct(mode) && ovf_evt) |=> rd_data[0]);
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00 && rd_data[4:3] == 2'b00);
endmodule

// File: tb/sim_tmr_flag_reg.sv
module sim_tmr_flag_reg;
  localparam int CW = 4;
  localparam int NV = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick;
  logic [CW-1:0] cnt, cmp_a, cmp_b, cap_val;
  logic          force_a, force_b, cap_evt, top_is_cap, ovf_evt, alt_ovf_evt;
  logic [3:0]    mode, ack, irq_en, irq;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_flag_reg #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_a(cmp_a),
    .cmp_b(cmp_b), .force_a(force_a), .force_b(force_b), .cap_evt(cap_evt),
    .cap_val(cap_val), .top_is_cap(top_is_cap), .mode(mode),
    .ovf_evt(ovf_evt), .alt_ovf_evt(alt_ovf_evt), .ack(ack), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_en(irq_en), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick = 0; force_a = 0; force_b = 0; cap_evt = 0; ovf_evt = 0;
    alt_ovf_evt = 0; ack = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 8'hFF; step();
  endtask

  initial begin
    idle(); cnt = 0; cmp_a = 0; cmp_b = 0; cap_val = 0; top_is_cap = 0;
    mode = 0; irq_en = 0;
    #23; chk("R1 reset rd", rd_data, 8'h00); chk("R1 reset irq", {4'h0, irq}, 8'h00);
    @(negedge clk); rst_n = 1; @(negedge clk);
    // make compare values unreachable by default
    cnt = 0; cmp_a = 4'hF; cmp_b = 4'hF;
    wr_en = 1; wr_data = 8'hFF; step();
    chk("R2 reserved write", rd_data, 8'h00);

    // R3 capture pulse
    cap_evt = 1; step(); chk("R3 no tick", rd_data, 8'h00);
    cap_evt = 1; tick = 1; step(); chk("R3 set", rd_data, 8'h20);
    clear_all();

    // R4 capture register as TOP: sweep
    top_is_cap = 1;
    for (int c = 0; c < NV; c++) for (int v = 0; v < NV; v++) begin
      cnt = c[CW-1:0]; cap_val = v[CW-1:0]; cap_evt = 1; tick = 1;
      cmp_a = ~cnt; cmp_b = ~cnt;
      step();
      chk("R4 top hit", rd_data, (c == v) ? 8'h20 : 8'h00);
      clear_all(); step();
    end
    top_is_cap = 0; cap_val = 0;

    // R5 compare delay sweep
    for (int c = 0; c < NV; c++) for (int m = 0; m < NV; m++) begin
      logic [7:0] e;
      e = {5'd0, (c == (NV-1-m)), (c == m), 1'b0};
      cnt = c[CW-1:0]; cmp_a = m[CW-1:0]; cmp_b = CW'(NV-1-m); tick = 1;
      step();
      chk("R5 not same tick", rd_data, 8'h00);
      cnt = m[CW-1:0] ^ 1; cmp_a = m[CW-1:0]; cmp_b = m[CW-1:0]; step();
      chk("R5 next tick idle", rd_data, 8'h00);
      tick = 1; step();
      chk("R5 next tick", rd_data, e);
      cmp_a = 4'hF; cmp_b = 4'hF; cnt = 0; clear_all(); step();
    end

    // R6 forced compare
    cnt = 3; cmp_a = 3; cmp_b = 3; force_a = 1; force_b = 1; tick = 1; step();
    cnt = 0; tick = 1; step(); chk("R6 force both", rd_data, 8'h00);
    cnt = 3; force_a = 1; tick = 1; step();
    cnt = 0; tick = 1; step(); chk("R6 force A only", rd_data, 8'h04);
    cmp_a = 4'hF; cmp_b = 4'hF; clear_all();

    // R7 overflow source per mode
    for (int md = 0; md < 16; md++) begin
      logic dir;
      dir = (md == 0) || (md == 4) || (md == 12);
      mode = md[3:0];
      ovf_evt = 1; tick = 1; step();
      chk("R7 ovf_evt", rd_data, {7'd0, dir}); clear_all();
      alt_ovf_evt = 1; tick = 1; step();
      chk("R7 alt_ovf_evt", rd_data, {7'd0, !dir}); clear_all();
    end
    mode = 0;

    // set all four flags
    cnt = 5; cmp_a = 5; cmp_b = 5; tick = 1; cap_evt = 1; ovf_evt = 1; step();
    cnt = 0; tick = 1; step();
    chk("R2 all flags", rd_data, 8'h27);

    // R12 enable sweep
    for (int en = 0; en < 16; en++) begin
      irq_en = en[3:0]; #1;
      chk("R12 irq", {4'h0, irq}, {4'h0, en[3:0]});
    end
    irq_en = 0;

    // R8 acknowledge each flag (R11: no tick)
    ack = 4'b0001; step(); chk("R8 ack ovf", rd_data, 8'h26);
    ack = 4'b0010; step(); chk("R8 ack A", rd_data, 8'h24);
    ack = 4'b0100; step(); chk("R8 ack B", rd_data, 8'h20);
    ack = 4'b1000; step(); chk("R11 ack cap no tick", rd_data, 8'h00);

    // R9 write-one / write-zero
    cnt = 5; tick = 1; cap_evt = 1; ovf_evt = 1; step();
    cnt = 0; tick = 1; step();
    wr_en = 1; wr_data = 8'hD8; step(); chk("R9 write zeros", rd_data, 8'h27);
    wr_en = 1; wr_data = 8'h21; step(); chk("R9 write one", rd_data, 8'h06);
    wr_en = 1; wr_data = 8'h06; step(); chk("R9 write one rest", rd_data, 8'h00);

    // R10 set beats clear
    ovf_evt = 1; tick = 1; ack = 4'b0001; step(); chk("R10 set vs ack", rd_data, 8'h01);
    cap_evt = 1; tick = 1; wr_en = 1; wr_data = 8'h21; step();
    chk("R10 set vs write", rd_data, 8'h20);
    clear_all();
    cmp_a = 4'hF; cmp_b = 4'hF;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule